// File: doc/BRIEF.md
# Manchester Transmit Encoder

This block turns a serial NRZ transmit stream into a Manchester-coded pair of complementary output bits. It runs from a reference clock at twice the bit rate. An internal half-cell phase bit divides that reference by two to give the bit clock, which is also exported as a stable bit-rate clock for receive-side logic. The transmit request and the data bit are sampled only at bit-cell boundaries. Each accepted bit therefore becomes a full two-half-cell symbol.

When the request is withdrawn, the output pair parks in one of two idle states. A mode input is captured at the moment the request drops. One state drives both outputs low, which gives zero differential for transformer-coupled loads. The other holds the positive output high and the negative output low. A new mode value takes effect only at the next drop.

Top module: `manchester_tx`

## Requirements
- R1: `bit_clk` toggles on every `clk_ref` rising edge. It is low during the first half of each bit cell and high during the second half, so it runs at half the reference rate.
- R2: While `rst_n` is low, `tx_p` and `tx_n` are both 0 and `bit_clk` is 1. The captured idle mode resets to the zero-differential state.
- R3: While a symbol is being sent, `tx_n` is the complement of `tx_p` in both half cells.
- R4: `tx_en` and `tx_data` are sampled at the `clk_ref` edge where `bit_clk` is 1, which ends a cell. If `tx_en` is 1, the next cell carries the symbol. Data 0 drives `tx_p` 1 in the first half and 0 in the second, a falling transition at mid-cell. Data 1 drives `tx_p` 0 and then 1, a rising transition at mid-cell.
- R5: Changes on `tx_en`, `tx_data` or `idle_hi` at the mid-cell edge have no effect. A symbol in progress always completes, and an idle cell stays idle.
- R6: If `idle_hi` is 0 when `tx_en` is first sampled low after a symbol, both outputs go to 0 for the whole idle period.
- R7: If `idle_hi` is 1 when `tx_en` is first sampled low after a symbol, the outputs hold `tx_p`=1 and `tx_n`=0 for the whole idle period.
- R8: Changes on `idle_hi` while the block is idle do not alter the idle output. Only the value at the next drop of `tx_en` matters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock at twice the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit request, sampled at cell boundaries |
| tx_data | input | 1 | NRZ data bit, sampled at cell boundaries |
| idle_hi | input | 1 | Idle-state select, captured when the request drops |
| tx_p | output | 1 | Positive coded output |
| tx_n | output | 1 | Negative coded output |
| bit_clk | output | 1 | Divided bit-rate clock |

## Verification
Two functions can fall on the same boundary edge: completing the last symbol and capturing the idle mode. The encoder must end the symbol and load the idle level from the freshly captured mode in that one edge, without using the stale mode. The bench provokes this by dropping `tx_en` while `idle_hi` takes a new value in the same cell. A mid-cell glitch is applied on top, so the drop also coincides with an ignored mid-cell edge. The scoreboard predicts every half cell of the outputs and of `bit_clk` from its own record of the captured mode, so a stale mode or a truncated symbol shows up as a mismatch in a named half cell.

// File: rtl/manchester_tx.sv
module manchester_tx (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic tx_en,
  input  logic tx_data,
  input  logic idle_hi,
  output logic tx_p,
  output logic tx_n,
  output logic bit_clk
);

  logic half;
  logic active;
  logic mode_q;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      half   <= 1'b1;
      active <= 1'b0;
      mode_q <= 1'b0;
      tx_p   <= 1'b0;
      tx_n   <= 1'b0;
    end else begin
      half <= ~half;
      if (half) begin
        active <= tx_en;
        if (active && !tx_en) mode_q <= idle_hi;
        if (tx_en) begin
          tx_p <= ~tx_data;
          tx_n <= tx_data;
        end else begin
          tx_p <= active ? idle_hi : mode_q;
          tx_n <= 1'b0;
        end
      end else if (active) begin
        tx_p <= ~tx_p;
        tx_n <= ~tx_n;
      end
    end
  end

  assign bit_clk = half;

  p_bitclk_fall_r1: assert property (@(posedge clk_ref) disable iff (!rst_n)
    half |=> !half);
  p_bitclk_rise_r1: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !half |=> half);
  p_complement_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    active |-> (tx_p != tx_n));
  p_mid_flip_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (active && !half) |=> (tx_p != $past(tx_p)));
  p_hold_midcell_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !half |=> $stable(active));
  p_idle_zero_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!active && !mode_q) |-> (!tx_p && !tx_n));
  p_idle_high_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!active && mode_q) |-> (tx_p && !tx_n));
  p_mode_steady_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!active && !$past(active)) |-> $stable(mode_q));

endmodule

// File: tb/tb_manchester_tx.sv
`timescale 1ns/1ps
module tb_manchester_tx;
  localparam int CLK_PERIOD = 50;

  typedef struct {
    logic  bclk;
    logic  p;
    logic  n;
    string tag;
  } item_t;

  logic clk = 0;
  logic rst_n = 0;
  logic tx_en = 0, tx_data = 0, idle_hi = 0;
  logic tx_p, tx_n, bit_clk;

  int checks = 0, fails = 0;
  bit done = 0;
  item_t q[$];
  logic exp_active = 0, exp_mode = 0;

  manchester_tx dut (
    .clk_ref(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_data(tx_data),
    .idle_hi(idle_hi), .tx_p(tx_p), .tx_n(tx_n), .bit_clk(bit_clk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(input logic b, input logic p, input logic n, input string tag);
    item_t it;
    it.bclk = b; it.p = p; it.n = n; it.tag = tag;
    q.push_back(it);
  endtask

  // One bit cell: drive at the negedge before a boundary, optionally glitch mid-cell
  task automatic send(input logic en, input logic d, input logic mode,
                      input logic glitch, input string tag);
    do @(negedge clk); while (bit_clk !== 1'b1);
    tx_en = en; tx_data = d; idle_hi = mode;
    if (en) begin
      push(1'b0, ~d, d, tag);
      push(1'b1, d, ~d, tag);
    end else begin
      if (exp_active) exp_mode = mode;
      push(1'b0, exp_mode, 1'b0, tag);
      push(1'b1, exp_mode, 1'b0, tag);
    end
    exp_active = en;
    if (glitch) begin
      @(negedge clk);
      tx_en = ~en; tx_data = ~d; idle_hi = ~mode;
    end
  endtask

  initial begin : monitor
    item_t it;
    wait (rst_n);
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (q.size() > 0) begin
        it = q.pop_front();
        check("R1 bit_clk", {1'b0, bit_clk}, {1'b0, it.bclk});
        check(it.tag, {tx_p, tx_n}, {it.p, it.n});
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    check("R2 reset outputs", {tx_p, tx_n}, 2'b00);
    check("R2 reset bit_clk", {1'b0, bit_clk}, 2'b01);
    idle_hi = 1;
    @(negedge clk);
    rst_n = 1;
    // idle from reset: mode reset to zero-differential despite idle_hi=1
    send(0, 0, 1, 0, "R2 idle after reset");
    send(0, 0, 1, 0, "R2 idle after reset");
    // basic data patterns
    send(1, 1, 0, 0, "R3 R4 data1");
    send(1, 0, 0, 0, "R3 R4 data0");
    send(1, 1, 0, 0, "R3 R4 data1");
    send(1, 1, 0, 0, "R3 R4 data1");
    send(1, 0, 0, 0, "R3 R4 data0");
    send(1, 0, 0, 0, "R3 R4 data0");
    // drop with high idle, then wiggle idle_hi while idle
    send(0, 0, 1, 0, "R7 idle high");
    send(0, 0, 0, 0, "R8 mode ignored idle");
    send(0, 0, 0, 1, "R8 R5 mode ignored idle glitch");
    send(0, 0, 1, 0, "R8 mode ignored idle");
    // mid-cell glitches during symbols
    send(1, 0, 0, 1, "R5 glitch data0");
    send(1, 1, 1, 1, "R5 glitch data1");
    // drop with zero idle
    send(0, 1, 0, 0, "R6 idle zero");
    send(0, 1, 1, 0, "R8 mode ignored idle");
    // alternating pattern
    for (int i = 0; i < 16; i++) send(1, i[0], 0, 0, "R4 alternating");
    // drop and mode change in the same cell, with mid-cell glitch
    send(0, 0, 1, 1, "R7 R5 drop with glitch");
    send(0, 0, 0, 0, "R8 mode ignored idle");
    send(1, 1, 0, 0, "R4 resume");
    send(0, 0, 0, 0, "R6 idle zero again");
    send(0, 0, 1, 0, "R8 mode ignored idle");
    wait (q.size() == 0);
    repeat (2) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule